// File: doc/BRIEF.md
# SDRAM Start-up and Refresh Sequencer

This block owns the command bus of a single-data-rate SDRAM from reset until the memory is usable. It then keeps the memory alive by refreshing it in the background. After a power-up settling wait, whose length is a parameter, it closes every bank. It issues two single auto-refresh commands and writes the mode register, which sets burst length, burst order and CAS latency. It then raises `ready` so that a downstream access engine may start using the memory. Each command is held for one cycle, and every wait cycle between commands carries a NOP.

Once `ready` is high, an interval timer expires at a fixed spacing given in clock cycles. A 4096-row device with a 64 ms retention time needs one refresh about every 15.6 us, which is 1562 cycles at 100 MHz. Each expiry leaves a refresh pending. The sequencer asks for the bus with `ref_req`. It waits until the access engine answers with `ref_gnt`, closes all banks, issues one auto-refresh and then hands the bus back. Refresh is therefore spread evenly over time rather than issued as a burst, and an auto-refresh is never sent while a bank could be open.

Top module: `sdram_init_refresh_seq`

## Requirements
- R1: Commands are encoded on (cs_n, ras_n, cas_n, we_n) as NOP=0111, precharge=0010, auto-refresh=0001 and mode-register load=0000. NOP, with address and bank zero, is driven during reset and in every cycle in which no command is issued.
- R2: The first command is a precharge of all banks with address bit 10 set and bank zero. It appears T_PWR clock edges after reset is released.
- R3: The start-up order is exactly precharge, auto-refresh, auto-refresh, mode-register load. The mode register is loaded only once, and an auto-refresh only ever follows a precharge or another auto-refresh.
- R4: The command after a precharge comes exactly T_RP cycles later, and the command after a start-up auto-refresh comes exactly T_RFC cycles later. No command comes earlier than the wait of the command before it.
- R5: The mode-register load uses bank zero. The address carries the burst-length code in bits 2..0 (1→0, 2→1, 4→2, 8→3, any other value→7), the interleaved-order flag in bit 3, the CAS latency in bits 6..4 and zero in all other bits.
- R6: `ready` is low until exactly T_MRD cycles after the mode-register load. It then goes high and stays high.
- R7: `ref_req` first rises T_REFI+1 cycles after `ready` first goes high. It rises again every T_REFI cycles, provided each refresh finishes within its interval.
- R8: `ref_gnt` has no effect while no refresh is requested. While a request is waiting for its grant, only NOP is driven.
- R9: If `ref_gnt` is high in a cycle while a request waits, precharge-all appears in the next cycle. Auto-refresh follows T_RP cycles after that, and `ref_req` falls T_RFC cycles after the auto-refresh.
- R10: While `ready` is high and `ref_req` is low, the block drives only NOP, leaving the bus to the access engine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_gnt | input | 1 | Access engine has released the bus for a refresh |
| ready | output | 1 | Start-up finished; memory usable |
| ref_req | output | 1 | Refresh wants the bus |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_ba | output | BA_W | Bank address |
| cmd_addr | output | ADDR_W | Address bus |

## Verification
The assertions check several rules on every cycle:
- auto-refresh only follows a precharge or auto-refresh;
- the mode register is written once;
- no command comes sooner than the wait of the one before it;
- `ready` never rises before the mode load and never falls;
- the bus stays quiet while the engine owns it;
- interval expiries are exactly T_REFI apart, and a grant only consumes a pending refresh.

The exact cycle of each start-up command, the mode-register bit layout and the exact rise of `ref_req` can only be shown by the bench's scenarios. The same holds for the command positions under grant latencies swept from zero to five cycles, and for the absence of any effect from an unrequested grant.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } sdr_cmd_e;

  typedef enum logic [3:0] {
    ST_PRE,
    ST_REF_A,
    ST_REF_B,
    ST_MRS,
    ST_MRS_WAIT,
    ST_RUN,
    ST_GNT_WAIT,
    ST_RPRE,
    ST_RREF,
    ST_RREF_WAIT
  } seq_step_e;

  function automatic logic [2:0] burst_len_code(input int unsigned len);
    case (len)
      1:       return 3'd0;
      2:       return 3'd1;
      4:       return 3'd2;
      8:       return 3'd3;
      default: return 3'd7;
    endcase
  endfunction

  function automatic logic [15:0] mode_word(input int unsigned len,
                                            input int unsigned cas,
                                            input logic interleave);
    logic [15:0] w;
    w      = '0;
    w[2:0] = burst_len_code(len);
    w[3]   = interleave;
    w[6:4] = 3'(cas);
    return w;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned bits_for(input int unsigned v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

endpackage

// File: rtl/sdr_gap_timer.sv
module sdr_gap_timer #(
  parameter int unsigned GW        = 4,
  parameter int unsigned RESET_VAL = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [GW-1:0] load_val,
  output logic          zero
);

  logic [GW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= GW'(RESET_VAL);
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // A new wait may only start once the previous one has run out.
  assert_load_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> zero);

endmodule

// File: rtl/sdr_refi_timer.sv
module sdr_refi_timer #(
  parameter int unsigned T_REFI = 1562,
  parameter int unsigned CW     = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  output logic tick,
  output logic pending
);

  localparam int unsigned AW = CW + 1;

  logic [CW-1:0] cnt;

  assign tick = en && (cnt == CW'(T_REFI - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!en)    cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  // A fresh expiry wins over a same-cycle grant.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending <= 1'b0;
    else        pending <= tick | (pending & ~clr);
  end

  // Independent age counter for the period check.
  logic [AW-1:0] age;
  logic          seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age  <= '0;
      seen <= 1'b0;
    end else begin
      seen <= seen | tick;
      if (tick)            age <= AW'(1);
      else if (age != '1)  age <= age + 1'b1;
    end
  end

  assert_tick_period_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && seen) |-> (age == AW'(T_REFI)));

  assert_grant_needs_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> pending);

endmodule

// File: rtl/sdr_cmd_drive.sv
module sdr_cmd_drive
  import sdr_seq_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned BA_W      = 2,
  parameter logic [15:0] MODE_BITS = 16'h0
) (
  input  sdr_cmd_e          cmd,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr
);

  localparam int unsigned ALL_BANKS_BIT = 10;

  assign {cs_n, ras_n, cas_n, we_n} = cmd;
  assign ba = '0;

  always_comb begin
    addr = '0;
    case (cmd)
      CMD_PRE: addr[ALL_BANKS_BIT] = 1'b1;
      CMD_MRS: addr = MODE_BITS[ADDR_W-1:0];
      default: addr = '0;
    endcase
  end

endmodule

// File: rtl/sdram_init_refresh_seq.sv
module sdram_init_refresh_seq
  import sdr_seq_pkg::*;
#(
  parameter int unsigned ADDR_W           = 12,
  parameter int unsigned BA_W             = 2,
  parameter int unsigned T_PWR            = 20000,
  parameter int unsigned T_RP             = 3,
  parameter int unsigned T_RFC            = 7,
  parameter int unsigned T_MRD            = 2,
  parameter int unsigned T_REFI           = 1562,
  parameter int unsigned BURST_LEN        = 4,
  parameter int unsigned CAS_LAT          = 3,
  parameter int unsigned BURST_INTERLEAVE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_gnt,
  output logic              ready,
  output logic              ref_req,
  output logic              cmd_cs_n,
  output logic              cmd_ras_n,
  output logic              cmd_cas_n,
  output logic              cmd_we_n,
  output logic [BA_W-1:0]   cmd_ba,
  output logic [ADDR_W-1:0] cmd_addr
);

  localparam int unsigned MAXW   = max2(max2(T_PWR, T_RP), max2(T_RFC, T_MRD));
  localparam int unsigned GW     = bits_for(MAXW);
  localparam int unsigned SW     = GW + 1;
  localparam int unsigned REFI_W = bits_for(T_REFI);
  localparam logic [15:0] MODE_V = mode_word(BURST_LEN, CAS_LAT, BURST_INTERLEAVE != 0);

  seq_step_e     step, nxt;
  sdr_cmd_e      cmd;
  logic          gap_zero, gap_load;
  logic [GW-1:0] gap_val;
  logic          pend_clr, refi_tick, refi_pending;

  sdr_gap_timer #(.GW(GW), .RESET_VAL(T_PWR)) u_gap (
    .clk(clk), .rst_n(rst_n), .load(gap_load), .load_val(gap_val), .zero(gap_zero)
  );

  sdr_refi_timer #(.T_REFI(T_REFI), .CW(REFI_W)) u_refi (
    .clk(clk), .rst_n(rst_n), .en(ready), .clr(pend_clr),
    .tick(refi_tick), .pending(refi_pending)
  );

  sdr_cmd_drive #(.ADDR_W(ADDR_W), .BA_W(BA_W), .MODE_BITS(MODE_V)) u_drv (
    .cmd(cmd), .cs_n(cmd_cs_n), .ras_n(cmd_ras_n), .cas_n(cmd_cas_n),
    .we_n(cmd_we_n), .ba(cmd_ba), .addr(cmd_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step <= ST_PRE;
    else        step <= nxt;
  end

  always_comb begin
    nxt      = step;
    cmd      = CMD_NOP;
    gap_load = 1'b0;
    gap_val  = '0;
    pend_clr = 1'b0;
    case (step)
      ST_PRE: if (gap_zero) begin
        cmd = CMD_PRE; gap_load = 1'b1; gap_val = GW'(T_RP - 1); nxt = ST_REF_A;
      end
      ST_REF_A: if (gap_zero) begin
        cmd = CMD_REF; gap_load = 1'b1; gap_val = GW'(T_RFC - 1); nxt = ST_REF_B;
      end
      ST_REF_B: if (gap_zero) begin
        cmd = CMD_REF; gap_load = 1'b1; gap_val = GW'(T_RFC - 1); nxt = ST_MRS;
      end
      ST_MRS: if (gap_zero) begin
        cmd = CMD_MRS; gap_load = 1'b1; gap_val = GW'(T_MRD - 1); nxt = ST_MRS_WAIT;
      end
      ST_MRS_WAIT:  if (gap_zero) nxt = ST_RUN;
      ST_RUN:       if (refi_pending) nxt = ST_GNT_WAIT;
      ST_GNT_WAIT: if (ref_gnt) begin
        pend_clr = 1'b1; nxt = ST_RPRE;
      end
      ST_RPRE: if (gap_zero) begin
        cmd = CMD_PRE; gap_load = 1'b1; gap_val = GW'(T_RP - 1); nxt = ST_RREF;
      end
      ST_RREF: if (gap_zero) begin
        cmd = CMD_REF; gap_load = 1'b1; gap_val = GW'(T_RFC - 1); nxt = ST_RREF_WAIT;
      end
      ST_RREF_WAIT: if (gap_zero) nxt = ST_RUN;
      default: nxt = ST_PRE;
    endcase
  end

  assign ready = (step == ST_RUN) || (step == ST_GNT_WAIT) || (step == ST_RPRE) ||
                 (step == ST_RREF) || (step == ST_RREF_WAIT) ||
                 ((step == ST_MRS_WAIT) && gap_zero);

  assign ref_req = (step == ST_GNT_WAIT) || (step == ST_RPRE) || (step == ST_RREF) ||
                   ((step == ST_RREF_WAIT) && !gap_zero);

  // ---------------- assertion support: history of issued commands ----------------
  sdr_cmd_e      last_cmd;
  logic          prev_valid, mrs_seen;
  logic [SW-1:0] since, need_gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_cmd   <= CMD_NOP;
      prev_valid <= 1'b0;
      mrs_seen   <= 1'b0;
      since      <= '0;
    end else if (cmd != CMD_NOP) begin
      last_cmd   <= cmd;
      prev_valid <= 1'b1;
      mrs_seen   <= mrs_seen | (cmd == CMD_MRS);
      since      <= SW'(1);
    end else if (since != '1) begin
      since <= since + 1'b1;
    end
  end

  always_comb begin
    case (last_cmd)
      CMD_PRE: need_gap = SW'(T_RP);
      CMD_REF: need_gap = SW'(T_RFC);
      CMD_MRS: need_gap = SW'(T_MRD);
      default: need_gap = '0;
    endcase
  end

  assert_ref_after_close_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_REF) |-> (prev_valid && (last_cmd == CMD_PRE || last_cmd == CMD_REF)));

  assert_single_mode_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_MRS) |-> !mrs_seen);

  assert_min_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd != CMD_NOP) && prev_valid) |-> (since >= need_gap));

  assert_ready_after_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> mrs_seen);

  assert_ready_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ready) |-> ready);

  assert_engine_owns_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !ref_req) |-> (cmd == CMD_NOP));

endmodule

// File: tb/sim_sdram_init_refresh_seq.sv
`timescale 1ns/1ps
module sim_sdram_init_refresh_seq;

  localparam int ADDR_W = 12;
  localparam int BA_W   = 2;
  localparam int T_PWR  = 10;
  localparam int T_RP   = 2;
  localparam int T_RFC  = 5;
  localparam int T_MRD  = 3;
  localparam int T_REFI = 40;
  localparam int BL     = 4;
  localparam int CL     = 3;
  localparam int IL     = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_gnt = 1'b0;
  logic ready, ref_req, cs_n, ras_n, cas_n, we_n;
  logic [BA_W-1:0]   ba;
  logic [ADDR_W-1:0] addr;
  logic [3:0] code;

  always #4 clk = ~clk;

  sdram_init_refresh_seq #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .T_PWR(T_PWR), .T_RP(T_RP), .T_RFC(T_RFC),
    .T_MRD(T_MRD), .T_REFI(T_REFI), .BURST_LEN(BL), .CAS_LAT(CL), .BURST_INTERLEAVE(IL)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ready(ready), .ref_req(ref_req),
    .cmd_cs_n(cs_n), .cmd_ras_n(ras_n), .cmd_cas_n(cas_n), .cmd_we_n(we_n),
    .cmd_ba(ba), .cmd_addr(addr)
  );

  assign code = {cs_n, ras_n, cas_n, we_n};

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
  endtask

  // Mode word restated arithmetically: length code is log2 for 1..8.
  function automatic logic [ADDR_W-1:0] exp_mode();
    int lc;
    lc = (BL == 1 || BL == 2 || BL == 4 || BL == 8) ? $clog2(BL) : 7;
    return ADDR_W'(lc + IL * 8 + CL * 16);
  endfunction

  localparam int T_R1  = T_PWR + T_RP;
  localparam int T_R2  = T_R1 + T_RFC;
  localparam int T_M   = T_R2 + T_RFC;
  localparam int T_RDY = T_M + T_MRD;

  initial begin
    repeat (4) @(negedge clk);
    chk(code == 4'b0111, "R1 reset NOP", 32'(code), 32'h7);
    chk(addr == '0 && ba == '0, "R1 reset address", 32'(addr), 0);
    chk(!ready, "R6 reset ready", 32'(ready), 0);
    chk(!ref_req, "R7 reset request", 32'(ref_req), 0);
    rst_n = 1'b1;
    cyc = 0;

    // Start-up sequence, cycle by cycle.
    for (int c = 1; c <= T_RDY; c++) begin
      logic [3:0] e;
      step();
      e = (cyc == T_PWR) ? 4'b0010 :
          (cyc == T_R1 || cyc == T_R2) ? 4'b0001 :
          (cyc == T_M) ? 4'b0000 : 4'b0111;
      if (cyc == T_PWR)      chk(code == e, "R2 first precharge", 32'(code), 32'(e));
      else if (e != 4'b0111) chk(code == e, "R3/R4 start-up order and spacing", 32'(code), 32'(e));
      else                   chk(code == e, "R1 NOP in wait", 32'(code), 32'(e));
      if (cyc == T_PWR)
        chk(addr == ADDR_W'(1 << 10) && ba == '0, "R2 precharge-all address", 32'(addr), 32'h400);
      if (cyc == T_M)
        chk(addr == exp_mode() && ba == '0, "R5 mode word", 32'(addr), 32'(exp_mode()));
      chk(ready == (cyc >= T_RDY), "R6 ready timing", 32'(ready), 32'(cyc >= T_RDY));
      chk(!ref_req, "R10 no request during start-up", 32'(ref_req), 0);
    end

    // Periodic refresh, sweeping grant latency 0..5.
    for (int k = 0; k < 6; k++) begin
      int q, g, p, rf, f;
      q = T_RDY + T_REFI + 1 + k * T_REFI;
      while (cyc < q - 1) begin
        step();
        chk(code == 4'b0111 && !ref_req, "R8/R10 idle bus", 32'({ref_req, code}), 32'h7);
        chk(ready, "R6 ready sticky", 32'(ready), 1);
        if (k == 0) ref_gnt = (cyc >= T_RDY + 5) && (cyc < T_RDY + 15);
      end
      ref_gnt = 1'b0;
      step();
      chk(ref_req, "R7 request timing", 32'(ref_req), 1);
      chk(code == 4'b0111, "R8 NOP while requesting", 32'(code), 32'h7);
      for (int j = 0; j < k; j++) begin
        step();
        chk(ref_req && code == 4'b0111, "R8 wait for grant", 32'({ref_req, code}), 32'h17);
      end
      ref_gnt = 1'b1;
      g  = cyc;
      p  = g + 1;
      rf = p + T_RP;
      f  = rf + T_RFC;
      while (cyc < f) begin
        logic [3:0] e;
        step();
        e = (cyc == p) ? 4'b0010 : (cyc == rf) ? 4'b0001 : 4'b0111;
        chk(code == e, "R9 refresh command placement", 32'(code), 32'(e));
        if (cyc == p)
          chk(addr == ADDR_W'(1 << 10), "R9 precharge-all before refresh", 32'(addr), 32'h400);
        chk(ref_req == (cyc < f), "R9 bus release", 32'(ref_req), 32'(cyc < f));
        chk(ready, "R6 ready sticky", 32'(ready), 1);
      end
      ref_gnt = 1'b0;
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R9: actual not finished expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule